// File: doc/BRIEF.md
# I2C Register-Pointer Slave

This block is an I2C slave that gives an external bus master byte-wide access to a small on-chip register file. It runs entirely on the system clock. SCL and SDA are oversampled through synchronizers, and the block watches them for start, stop and repeated-start conditions. It decodes the device address byte and acknowledges it when the address matches. SDA is pulled low through an output enable. The slave never drives the line high.

A single register pointer selects the location to access. In a write transfer, the first byte after the device address loads the pointer. Each later byte is stored at the pointer, and the pointer then steps forward by one. A master reads a chosen location by writing the pointer, issuing a repeated start, and re-addressing the slave for reading. The pointer is kept across transactions. A read that begins directly after the address byte therefore continues from the location that follows the last byte of the previous access.

Top module: `i2c_regptr_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and stays 0 until a matching address byte has been received.
- R2: An address byte is sent MSB first. Bits 7:1 carry the 7-bit device address and bit 0 carries the direction (0 = write, 1 = read). When bits 7:1 equal `DEV_ADDR`, the slave pulls SDA low during the ninth clock.
- R3: When the address does not match, the slave does not acknowledge. It drives nothing, and it stores and changes nothing, until the next start or stop. A read sent to another address returns 8'hFF on the idle-high line.
- R4: In a write transfer, the first byte after the address byte loads the pointer from its low bits and is acknowledged. It is not written into the register file.
- R5: Every further write byte is stored at the pointer and acknowledged. The pointer then advances by one, wrapping from the last location (15 by default) to 0.
- R6: After a repeated start with direction 1, the slave sends the byte at the current pointer, MSB first, without losing the pointer written just before.
- R7: Every transmitted byte advances the pointer by one, with wrap. When the master answers with acknowledge 0, the slave sends the byte at the new pointer.
- R8: When the master answers a transmitted byte with acknowledge 1, the slave releases SDA and leaves it released until the next start or stop.
- R9: The pointer survives a stop. A read with no pointer phase starts at the location after the last byte of the previous write or read.
- R10: The slave turns SDA drive on or off only while synchronized SCL is low, except that a start or a stop always releases SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Registered; 1 pulls SDA low, 0 releases it |

## Verification
The assertions check on every cycle that SDA drive changes only while synchronized SCL is low, that start and stop conditions and the ignore state leave SDA released, and that the pointer moves only by a load or by a step of exactly one. Only the bench scenarios can show the data contents: which bytes are stored where, that the pointer-load byte is not stored, that wrap-around lands on location 0, and that a current-address read resumes at the right location after a stop. Ignored traffic is shown the same way, by reading the affected locations and the pointer back through the bus afterwards.

// File: rtl/i2c_regptr_pkg.sv
package i2c_regptr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,    // no transaction for this slave
    ST_RX,      // shifting in a byte from the master
    ST_RX_END,  // eight bits in, waiting for SCL low to act
    ST_ACK,     // slave holding SDA low for the ninth clock
    ST_TX,      // shifting out a byte to the master
    ST_TX_ACK,  // ninth clock of a read byte, master answers
    ST_IGNORE   // not addressed or read finished: hands off
  } slv_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_regfile.sv
module i2c_regfile #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_regptr_slave.sv
module i2c_regptr_slave
  import i2c_regptr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h51,
  parameter int         REGS        = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int AW = $clog2(REGS);
  localparam int DW = 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  slv_state_t    state;
  logic [2:0]    bit_cnt;
  logic [DW-1:0] rx_sh, tx_sh;
  logic          is_addr;   // byte being received is the address byte
  logic          ptr_phase; // next write byte loads the pointer
  logic          rd_mode;
  logic          more;      // master asked for another byte
  logic [AW-1:0] ptr;
  logic          ptr_load;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata, rd_data;
  logic          ignoring;

  i2c_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(rd_data)
  );

  assign ignoring = (state == ST_IGNORE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      is_addr   <= 1'b0;
      ptr_phase <= 1'b0;
      rd_mode   <= 1'b0;
      more      <= 1'b0;
      ptr       <= '0;
      ptr_load  <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      sda_oe    <= 1'b0;
    end else begin
      mem_we   <= 1'b0;
      ptr_load <= 1'b0;
      if (start_det) begin
        state   <= ST_RX;
        bit_cnt <= '0;
        is_addr <= 1'b1;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: if (scl_rise) begin
            rx_sh   <= {rx_sh[DW-2:0], sda_s};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) state <= ST_RX_END;
          end
          ST_RX_END: if (scl_fall) begin
            if (is_addr) begin
              is_addr <= 1'b0;
              if (rx_sh[7:1] == DEV_ADDR) begin
                sda_oe    <= 1'b1;
                rd_mode   <= rx_sh[0];
                ptr_phase <= ~rx_sh[0];
                state     <= ST_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end else begin
              sda_oe <= 1'b1;
              state  <= ST_ACK;
              if (ptr_phase) begin
                ptr       <= rx_sh[AW-1:0];
                ptr_load  <= 1'b1;
                ptr_phase <= 1'b0;
              end else begin
                mem_we    <= 1'b1;
                mem_waddr <= ptr;
                mem_wdata <= rx_sh;
                ptr       <= ptr + 1'b1;
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            bit_cnt <= '0;
            if (rd_mode) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[DW-1];
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
          ST_TX: if (scl_fall) begin
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              sda_oe <= 1'b0;
              state  <= ST_TX_ACK;
            end else begin
              tx_sh  <= {tx_sh[DW-2:0], 1'b0};
              sda_oe <= ~tx_sh[DW-2];
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              ptr  <= ptr + 1'b1;
              more <= ~sda_s;
            end else if (scl_fall) begin
              if (more) begin
                bit_cnt <= '0;
                tx_sh   <= rd_data;
                sda_oe  <= ~rd_data[DW-1];
                state   <= ST_TX;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regptr_chk.sv
module i2c_regptr_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_s,
  input logic          start_det,
  input logic          stop_det,
  input logic          sda_oe,
  input logic [AW-1:0] ptr,
  input logic          ptr_load,
  input logic          ignoring
);
  // R1: drive is off in the first cycle after reset
  a_r1_reset_released: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !sda_oe);

  // R10: drive turns on only while SCL is low
  a_r10_drive_on_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_s));

  // R10: drive turns off only while SCL is low, unless a start or stop ended it
  a_r10_release_scl_low: assert property (@(posedge clk) disable iff (rst)
    ($fell(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s));

  // R10: start and stop conditions release the line
  a_r10_start_release: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);
  a_r10_stop_release: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R3, R8: hands off while not addressed or after a finished read
  a_r3_ignore_quiet: assert property (@(posedge clk) disable iff (rst)
    ignoring |-> !sda_oe);

  // R5, R7: apart from a load, the pointer only steps by one
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (ptr != $past(ptr) && !ptr_load) |-> ptr == AW'($past(ptr) + 1'b1));
endmodule

bind i2c_regptr_slave i2c_regptr_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .ptr(ptr), .ptr_load(ptr_load),
  .ignoring(ignoring)
);

// File: tb/i2c_regptr_slave_bench.sv
module i2c_regptr_slave_bench;
  localparam logic [6:0] DEV = 7'h51;
  localparam logic [6:0] OTHER = 7'h23;
  localparam int Q = 10;   // quarter bus period in clocks

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_regptr_slave #(.DEV_ADDR(DEV)) u_i2c_regptr_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] model_mem [16];
  logic [3:0] model_ptr = '0;

  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  string      tag_q [$];

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() != 0 && exp_q.size() != 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(g === e, t, g, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %h expected %h", 8'h00, 8'h01);
    finish_run();
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    sda_m = 1'b0; wq(2*Q);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wq(Q); sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic bit_xfer(input logic b, output logic r);
    wq(Q); sda_m = b; wq(Q);
    scl_m = 1'b1; wq(Q);
    r = sda_line; wq(Q);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_xfer(d[i], r);
    bit_xfer(1'b1, ack);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, r);
      d[i] = r;
    end
    bit_xfer(nack, r);
  endtask

  function automatic logic [7:0] pat(input int k, input logic [7:0] seed);
    return seed ^ 8'(k * 8'h1D + 3);
  endfunction

  // write n bytes starting at reg; n = 0 loads the pointer only
  task automatic wr_burst(input logic [3:0] reg_a, input int n, input logic [7:0] seed);
    logic ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk(ack == 1'b0, "R2 address ack", {7'd0, ack}, 8'h00);
    send_byte({4'h0, reg_a}, ack);
    chk(ack == 1'b0, "R4 pointer byte ack", {7'd0, ack}, 8'h00);
    model_ptr = reg_a;
    for (int k = 0; k < n; k++) begin
      logic [7:0] v;
      v = pat(k, seed);
      send_byte(v, ack);
      chk(ack == 1'b0, "R5 data ack", {7'd0, ack}, 8'h00);
      model_mem[model_ptr] = v;
      model_ptr = model_ptr + 1'b1;
    end
    bus_stop();
  endtask

  task automatic rd_bytes(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      exp_q.push_back(model_mem[model_ptr]);
      tag_q.push_back(tag);
      recv_byte(k == n - 1, d);
      got_q.push_back(d);
      model_ptr = model_ptr + 1'b1;
    end
    wq(Q);
    chk(sda_oe == 1'b0, "R8 released after nack", {7'd0, sda_oe}, 8'h00);
    bus_stop();
  endtask

  task automatic rd_at(input logic [3:0] reg_a, input int n, input string tag);
    logic ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk(ack == 1'b0, "R2 address ack", {7'd0, ack}, 8'h00);
    send_byte({4'h0, reg_a}, ack);
    chk(ack == 1'b0, "R4 pointer byte ack", {7'd0, ack}, 8'h00);
    model_ptr = reg_a;
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    chk(ack == 1'b0, "R6 repeated-start read ack", {7'd0, ack}, 8'h00);
    rd_bytes(n, tag);
  endtask

  task automatic rd_cur(input int n, input string tag);
    logic ack;
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    chk(ack == 1'b0, "R9 current read ack", {7'd0, ack}, 8'h00);
    rd_bytes(n, tag);
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    wq(3);
    chk(sda_oe == 1'b0, "R1 reset released", {7'd0, sda_oe}, 8'h00);

    // R5: fill all 16 registers, pointer wraps to 0
    wr_burst(4'd0, 16, 8'hA5);
    // R6 R7: repeated-start read of four bytes from 3
    rd_at(4'd3, 4, "R7 read burst from 3");
    // R9: current read resumes at 7 after the read ended at 6
    rd_cur(2, "R9 current read after read");
    // R5: write burst wrapping 14,15,0,1
    wr_burst(4'd14, 4, 8'h3C);
    rd_cur(1, "R9 current read after write");
    // R4: pointer-only write, nothing stored
    wr_burst(4'd9, 0, 8'h00);
    rd_cur(2, "R4 pointer load not stored");
    // R7: read wrapping 15,0,1
    rd_at(4'd15, 3, "R7 read wrap");

    // R3: write to another device must be ignored
    bus_start();
    send_byte({OTHER, 1'b0}, ack);
    chk(ack == 1'b1, "R3 foreign address not acked", {7'd0, ack}, 8'h01);
    send_byte(8'h00, ack);
    chk(ack == 1'b1, "R3 foreign pointer not acked", {7'd0, ack}, 8'h01);
    send_byte(8'h55, ack);
    chk(ack == 1'b1, "R3 foreign data not acked", {7'd0, ack}, 8'h01);
    bus_stop();
    rd_cur(1, "R3 pointer untouched by foreign write");
    rd_at(4'd0, 1, "R3 register untouched by foreign write");

    // R3: read from another device sees idle line
    bus_start();
    send_byte({OTHER, 1'b1}, ack);
    chk(ack == 1'b1, "R3 foreign read not acked", {7'd0, ack}, 8'h01);
    recv_byte(1'b1, d);
    chk(d == 8'hFF, "R3 foreign read idle", d, 8'hFF);
    bus_stop();
    rd_cur(1, "R9 pointer kept over foreign read");

    wq(20);
    chk(exp_q.size() == 0, "R6 scoreboard drained", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule